// File: doc/BRIEF.md
# I2C Read-Only Target with Own-Address Match

This block is the target side of an I2C bus that answers read requests. It watches synchronised copies of SCL and SDA, finds start and stop conditions, and shifts in the first byte after each start. The upper seven bits of that byte are compared with a programmable own address, and the lowest bit gives the direction. When the address matches and a read is requested, the block acknowledges the byte. It then shifts out bytes taken from a transmit stream that uses valid/ready handshaking, and samples the master's acknowledge after each byte.

The block drives SDA only through a pull-low enable, which is meant for an open-drain pad. It reports three conditions as single-cycle events, and each has its own enable bit. The first is an address match with no data waiting. The second is a byte the master did not acknowledge. The third is a byte marked as the last of a buffer reaching its acknowledge clock. It does not act as a master, does not stretch the clock and does not take in write data.

States of the controller: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_END`, `ST_ACK_RD`, `ST_ACK_WR`, `ST_TX`, `ST_TX_ACK`, `ST_TX_NEXT`, `ST_UNDER` and `ST_SKIP`.

Transitions:
- A start goes from any state to `ST_ADDR`.
- A stop goes from any state to `ST_IDLE`.
- In `ST_ADDR`, the eighth SCL rise leads to `ST_ADDR_END`.
- In `ST_ADDR_END`, the next SCL fall leads to one of four states:
  - `ST_SKIP` on an address mismatch;
  - `ST_ACK_WR` on a matching write;
  - `ST_ACK_RD` on a matching read with data valid, and the byte is taken;
  - `ST_SKIP` on a matching read with no data, and the no-data event is raised.
- In `ST_ACK_RD`, the SCL fall leads to `ST_TX`.
- In `ST_ACK_WR`, the SCL fall leads to `ST_SKIP`.
- In `ST_TX`, the SCL fall after the eighth bit leads to `ST_TX_ACK`.
- In `ST_TX_ACK`, the SCL rise samples SDA. A high level (NACK) leads to `ST_SKIP` and raises the abort event. A low level (ACK) leads to `ST_TX_NEXT`.
- In `ST_TX_NEXT`, the SCL fall leads to `ST_TX` if data is valid, and the byte is taken. Otherwise it leads to `ST_UNDER`.

Top module: `i2c_rd_slave`

## Requirements
- R1: A start (SDA falls while SCL is high) restarts address reception from any state, including in the middle of a byte. A stop (SDA rises while SCL is high) returns the block to idle with SDA released.
- R2: The first byte after a start is compared, bits 7..1, with `own_addr`. On a mismatch SDA stays released for the acknowledge clock and for the rest of the transfer, until the next start.
- R3: A matching address with bit 0 = 1 (read) and `tx_valid` high is acknowledged by holding SDA low through the ninth SCL clock. `tx_ready` is a one-cycle pulse that is only ever high together with `tx_valid`.
- R4: Data bytes go out MSB first. The first bit is driven on the SCL pulse that follows the address acknowledge. SDA changes only while SCL is low.
- R5: A matching read with `tx_valid` low is not acknowledged. It raises `evt_no_data` (enabled by `evt_mask[0]`), and the transfer is then ignored.
- R6: A matching address with bit 0 = 0 (write) is acknowledged. Later bytes of that transfer are not acknowledged.
- R7: A NACK sampled on the ninth SCL rise after a data byte releases SDA for the rest of the transfer and raises `evt_abort` (enabled by `evt_mask[1]`).
- R8: A byte taken with `tx_last` high raises `evt_done` (enabled by `evt_mask[2]`) at its acknowledge clock, whether the master sends ACK or NACK.
- R9: If no data is valid when the next byte is due after an ACK, the block releases SDA, so the master reads 0xFF, until a stop. Acknowledges given during this underrun raise no abort event.
- R10: Each event is high for exactly one cycle per occurrence. It is suppressed entirely when its mask bit is 0.
- R11: After reset SDA is released, every event is low and `tx_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_drive_low | output | 1 | Pull SDA low when 1 (open-drain enable) |
| own_addr | input | 7 | Own 7-bit address |
| evt_mask | input | 3 | Event enables: [0] no data, [1] abort, [2] done |
| tx_data | input | 8 | Next byte to send |
| tx_valid | input | 1 | `tx_data` holds a byte |
| tx_last | input | 1 | The byte ends a buffer |
| tx_ready | output | 1 | The byte is taken this cycle |
| evt_no_data | output | 1 | Address matched but no data was ready |
| evt_abort | output | 1 | The master did not acknowledge a data byte |
| evt_done | output | 1 | The last byte of a buffer was sent |

## Verification
The bench sweeps every 7-bit address with the read bit set against a fixed own address. A comparator that looked at the wrong bits, or that included the direction bit, would acknowledge a stranger or miss its own address. Repeated starts are issued after a foreign address and in the middle of a byte; a design that failed to reset its bit counter would take the wrong eight bits as the address. An underrun is forced after an acknowledged last byte, and a design that reused stale data or pulled SDA low would return a value other than 0xFF and could block the stop. With all event enables cleared, the no-data, NACK and last-byte cases are run again. Masking applied in the wrong place, or pulses longer than one cycle, show up as wrong event counts.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ACK_RD,
        ST_ACK_WR,
        ST_TX,
        ST_TX_ACK,
        ST_TX_NEXT,
        ST_UNDER,
        ST_SKIP
    } rd_state_e;

    localparam int EVT_NUM    = 3;
    localparam int EV_NO_DATA = 0;
    localparam int EV_ABORT   = 1;
    localparam int EV_DONE    = 2;

endpackage

// File: rtl/i2c_rd_sense.sv
module i2c_rd_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_p;
    logic                   sda_p;

    // Synchroniser chains, idle-high after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh[0] <= scl_i;
            sda_sh[0] <= sda_i;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                scl_sh[i] <= scl_sh[i-1];
                sda_sh[i] <= sda_sh[i-1];
            end
            scl_p <= scl_sh[SYNC_STAGES-1];
            sda_p <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sh[SYNC_STAGES-1];
    assign sda_s     = sda_sh[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_rd_fsm.sv
module i2c_rd_fsm
    import i2c_rd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                sda_s,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic [DATA_W-2:0]   own_addr,
    input  logic [DATA_W-1:0]   tx_data,
    input  logic                tx_valid,
    input  logic                tx_last,
    output logic                tx_ready,
    output logic                sda_drive_low,
    output logic [EVT_NUM-1:0]  ev_raw,
    output rd_state_e           state
);

    localparam int              CNT_W    = $clog2(DATA_W) + 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    rd_state_e          state_q, state_d;
    logic [DATA_W-1:0]  rx_sh;
    logic [DATA_W-1:0]  tx_sh;
    logic [CNT_W-1:0]   bit_cnt;
    logic               last_q;
    logic               load;
    logic               addr_hit;
    logic               dir_rd;

    assign addr_hit = (rx_sh[DATA_W-1:1] == own_addr);
    assign dir_rd   = rx_sh[0];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        ev_raw  = '0;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (scl_rise && bit_cnt == LAST_BIT) state_d = ST_ADDR_END;
                end
                ST_ADDR_END: begin
                    if (scl_fall) begin
                        if (!addr_hit) begin
                            state_d = ST_SKIP;
                        end else if (!dir_rd) begin
                            state_d = ST_ACK_WR;
                        end else if (tx_valid) begin
                            state_d = ST_ACK_RD;
                            load    = 1'b1;
                        end else begin
                            state_d = ST_SKIP;
                            ev_raw[EV_NO_DATA] = 1'b1;
                        end
                    end
                end
                ST_ACK_RD: if (scl_fall) state_d = ST_TX;
                ST_ACK_WR: if (scl_fall) state_d = ST_SKIP;
                ST_TX: begin
                    if (scl_fall && bit_cnt == LAST_BIT) state_d = ST_TX_ACK;
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        ev_raw[EV_DONE] = last_q;
                        if (sda_s) begin
                            state_d = ST_SKIP;
                            ev_raw[EV_ABORT] = 1'b1;
                        end else begin
                            state_d = ST_TX_NEXT;
                        end
                    end
                end
                ST_TX_NEXT: begin
                    if (scl_fall) begin
                        if (tx_valid) begin
                            state_d = ST_TX;
                            load    = 1'b1;
                        end else begin
                            state_d = ST_UNDER;
                        end
                    end
                end
                ST_UNDER: state_d = ST_UNDER;
                ST_SKIP:  state_d = ST_SKIP;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift registers and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sh   <= '0;
            tx_sh   <= '1;
            bit_cnt <= '0;
            last_q  <= 1'b0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else if (load) begin
            tx_sh   <= tx_data;
            last_q  <= tx_last;
            bit_cnt <= '0;
        end else if (state_q == ST_ADDR && scl_rise) begin
            rx_sh   <= {rx_sh[DATA_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
        end else if (state_q == ST_TX && scl_fall && bit_cnt != LAST_BIT) begin
            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b1};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        tx_ready = load;
        state    = state_q;
        unique case (state_q)
            ST_ACK_RD, ST_ACK_WR: sda_drive_low = 1'b1;
            ST_TX:                sda_drive_low = ~tx_sh[DATA_W-1];
            default:              sda_drive_low = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_rd_evt.sv
module i2c_rd_evt #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] mask,
    output logic [N-1:0] evt
);

    for (genvar g = 0; g < N; g++) begin : g_evt
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt[g] <= 1'b0;
            else        evt[g] <= raw[g] & mask[g];
        end
    end

endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave
    import i2c_rd_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_drive_low,
    input  logic [DATA_W-2:0]   own_addr,
    input  logic [EVT_NUM-1:0]  evt_mask,
    input  logic [DATA_W-1:0]   tx_data,
    input  logic                tx_valid,
    input  logic                tx_last,
    output logic                tx_ready,
    output logic                evt_no_data,
    output logic                evt_abort,
    output logic                evt_done
);

    logic               scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [EVT_NUM-1:0] ev_raw, evt;
    rd_state_e          state;

    i2c_rd_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .sda_s         (sda_s),
        .start_det     (start_det),
        .stop_det      (stop_det),
        .own_addr      (own_addr),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_last       (tx_last),
        .tx_ready      (tx_ready),
        .sda_drive_low (sda_drive_low),
        .ev_raw        (ev_raw),
        .state         (state)
    );

    i2c_rd_evt #(.N(EVT_NUM)) u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (ev_raw),
        .mask  (evt_mask),
        .evt   (evt)
    );

    assign evt_no_data = evt[EV_NO_DATA];
    assign evt_abort   = evt[EV_ABORT];
    assign evt_done    = evt[EV_DONE];

endmodule

// File: rtl/i2c_rd_slave_chk.sv
module i2c_rd_slave_chk
    import i2c_rd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_s,
    input logic      sda_drive_low,
    input logic      tx_valid,
    input logic      tx_ready,
    input logic      evt_no_data,
    input logic      evt_abort,
    input logic      evt_done,
    input rd_state_e state
);

    p_drive_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> !scl_s);

    p_ready_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> tx_valid);

    p_ready_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |=> !tx_ready);

    p_nodata_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_no_data |=> !evt_no_data);

    p_abort_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_abort |=> !evt_abort);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_done |=> !evt_done);

    p_under_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UNDER) |-> !sda_drive_low);

    p_skip_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> !sda_drive_low);

    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_drive_low);

endmodule

bind i2c_rd_slave i2c_rd_slave_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_s         (scl_s),
    .sda_drive_low (sda_drive_low),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .evt_no_data   (evt_no_data),
    .evt_abort     (evt_abort),
    .evt_done      (evt_done),
    .state         (state)
);

// File: tb/test_i2c_rd_slave.sv
module test_i2c_rd_slave;

    localparam int Q = 8;
    localparam logic [6:0] OWN = 7'h2D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       drv;
    logic [6:0] own_addr = OWN;
    logic [2:0] evt_mask = 3'b111;
    logic [7:0] tx_data;
    logic       tx_valid, tx_last, tx_ready;
    logic       e_nd, e_ab, e_dn;

    logic [7:0] q_data [16];
    logic       q_last [16];
    logic [4:0] head = '0;
    logic [4:0] tail = '0;

    int n_nd = 0, n_ab = 0, n_dn = 0;
    int x_nd = 0, x_ab = 0, x_dn = 0;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign sda_bus  = sda_m & ~drv;
    assign tx_valid = (head != tail);
    assign tx_data  = q_data[head[3:0]];
    assign tx_last  = q_last[head[3:0]];

    always @(posedge clk) begin
        if (tx_valid && tx_ready) head <= head + 5'd1;
        if (e_nd) n_nd <= n_nd + 1;
        if (e_ab) n_ab <= n_ab + 1;
        if (e_dn) n_dn <= n_dn + 1;
    end

    i2c_rd_slave i_i2c_rd_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl_m),
        .sda_i         (sda_bus),
        .sda_drive_low (drv),
        .own_addr      (own_addr),
        .evt_mask      (evt_mask),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_last       (tx_last),
        .tx_ready      (tx_ready),
        .evt_no_data   (e_nd),
        .evt_abort     (e_ab),
        .evt_done      (e_dn)
    );

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic l);
        q_data[tail[3:0]] = d;
        q_last[tail[3:0]] = l;
        tail = tail + 5'd1;
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        r = sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic start_c();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic stop_c();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], r);
        bit_xfer(1'b1, r);
        ack = ~r;
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r);
            d[i] = r;
        end
        bit_xfer(~ack, r);
    endtask

    task automatic check_events(input string req);
        repeat (4) @(negedge clk);
        check(n_nd, x_nd, {req, " no-data count"});
        check(n_ab, x_ab, {req, " abort count"});
        check(n_dn, x_dn, {req, " done count"});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        // R11: reset state
        check(drv, 0, "R11 sda released");
        check(tx_ready, 0, "R11 ready low");
        check({e_nd, e_ab, e_dn}, 0, "R11 events low");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(drv, 0, "R11 released after reset");

        // R2/R3/R4: sweep all addresses, read direction
        push(8'hC3, 1'b1);
        for (int a = 0; a < 128; a++) begin
            start_c();
            write_byte({a[6:0], 1'b1}, ack);
            check(ack, (a == OWN) ? 1 : 0, "R2 R3 address ack");
            if (a == OWN) begin
                read_byte(1'b0, d);
                check(d, 8'hC3, "R4 first byte");
                x_ab++; x_dn++;
            end
            stop_c();
            check(drv, 0, "R1 released after stop");
        end
        check_events("R2 sweep");

        // R4/R7/R8: multi-byte read
        push(8'hA5, 1'b0); push(8'h00, 1'b0); push(8'h7E, 1'b1);
        start_c();
        write_byte({OWN, 1'b1}, ack);
        check(ack, 1, "R3 ack");
        read_byte(1'b1, d); check(d, 8'hA5, "R4 byte0");
        read_byte(1'b1, d); check(d, 8'h00, "R4 byte1");
        read_byte(1'b0, d); check(d, 8'h7E, "R4 byte2");
        x_ab++; x_dn++;
        check(drv, 0, "R7 released after nack");
        stop_c();
        check_events("R7 R8");

        // R5: match with no data
        start_c();
        write_byte({OWN, 1'b1}, ack);
        check(ack, 0, "R5 no ack without data");
        x_nd++;
        stop_c();
        check_events("R5");

        // R6: matching write
        start_c();
        write_byte({OWN, 1'b0}, ack);
        check(ack, 1, "R6 write addr ack");
        write_byte(8'h00, ack);
        check(ack, 0, "R6 data not acked");
        stop_c();
        check_events("R6");

        // R9: underrun
        push(8'h81, 1'b1);
        start_c();
        write_byte({OWN, 1'b1}, ack);
        check(ack, 1, "R9 ack");
        read_byte(1'b1, d); check(d, 8'h81, "R9 real byte");
        x_dn++;
        read_byte(1'b1, d); check(d, 8'hFF, "R9 underrun byte1");
        read_byte(1'b0, d); check(d, 8'hFF, "R9 underrun byte2");
        stop_c();
        check(drv, 0, "R9 released after stop");
        check_events("R9");

        // R1: repeated start after foreign address and mid-byte
        push(8'h5A, 1'b0);
        start_c();
        write_byte({OWN ^ 7'h01, 1'b1}, ack);
        check(ack, 0, "R1 foreign nack");
        start_c();
        for (int i = 0; i < 4; i++) bit_xfer(1'b0, ack);
        start_c();
        write_byte({OWN, 1'b1}, ack);
        check(ack, 1, "R1 ack after restart");
        read_byte(1'b0, d);
        check(d, 8'h5A, "R1 data after restart");
        x_ab++;
        stop_c();
        check_events("R1");

        // R10: masked events
        evt_mask = 3'b000;
        start_c();
        write_byte({OWN, 1'b1}, ack);
        check(ack, 0, "R10 masked no-data nack");
        stop_c();
        push(8'h3C, 1'b1);
        start_c();
        write_byte({OWN, 1'b1}, ack);
        read_byte(1'b0, d);
        check(d, 8'h3C, "R10 data");
        stop_c();
        check_events("R10 masked");
        evt_mask = 3'b111;

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule